// File: doc/BRIEF.md
# Double-Buffered PWM Output Channel

This block generates one pulse-width modulated waveform on a single pin. The system clock first passes through an 8-bit reload prescaler, and the prescaler's overflow advances a period counter. A compare stage sets the output active for a programmable number of counts at the end of each period. Software writes the period and pulse-width values into holding buffers. The working copies pick these up at the end of a period, or at once when bypass mode is set.

The same control word sets the pin role. With generation on, the pin is always an output and carries the waveform in either polarity. With generation off, the pin is a static output at a level chosen by the polarity bit, or it is an input. A read-only status bit returns the synchronised pin level. A qualified freeze input can halt the channel. A sticky flag records each period-end edge of the waveform and can raise an interrupt.

Top module: `pwm_channel`

## Requirements
- R1: Control word bit 14 is read-only and returns the pin_in level after the synchroniser. Bit 15 always reads 0. Writes to either bit have no effect.
- R2: With run (control bit 10) clear, pin_oe follows dir (control bit 8). With run set, pin_oe is 1 whatever dir holds.
- R3: With run clear and dir set, pin_out holds the value of pol (control bit 9).
- R4: The prescaler field (control bits 7:0) holds value P, and one count of the period counter lasts 256-P clocks. For example, P=0xFF gives one clock per count and P=0xFE gives two.
- R5: After run is set, the counter starts at 0 and counts 0 to period-1. The output is active while the count is at least period-pulse. It is active-high when pol is 0 and active-low when pol is 1. The pin shows the inactive level in the first cycle after enabling.
- R6: A pulse value of 0 keeps the output inactive. A nonzero pulse value equal to or above the period keeps it active.
- R7: With bypass (control bit 11) clear, a new period (address 0) or pulse (address 1) takes effect only at the next period boundary.
- R8: With bypass set, a write to address 0 or 1 while running loads the working value in the same clock.
- R9: With freeze-enable (control bit 12) set, freeze_in high stops the prescaler, the counter and the output. With freeze-enable clear, freeze_in is ignored.
- R10: Status bit 0 (address 3) is set when the output goes from active to inactive while running. It stays set until a write with bit 0 high. irq equals this flag ANDed with irq-enable (control bit 13).
- R11: Reads of addresses 0 and 1 return the buffered period and pulse values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |
| pin_in | input | 1 | Level present on the pad |
| pin_out | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad output enable |
| freeze_in | input | 1 | Halt request |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a few things about the inputs. A period of at least one count is programmed before run is set. Register writes are synchronous single-cycle strobes. pin_in and freeze_in change only between clock edges. To stay within these limits, the stimulus changes period and pulse only while the channel is stopped, or through one timed mid-run pulse write. Freeze is held steady across each run. Every waveform is predicted from the enable edge by counting prescaler periods, so no run depends on pre-reset counter state.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   localparam int DW    = 16;
   localparam int PSC_W = 8;

   typedef enum logic [1:0] {
      A_PER = 2'd0,
      A_PW  = 2'd1,
      A_CTL = 2'd2,
      A_STS = 2'd3
   } reg_addr_e;

   // Packed so that it maps directly onto control word bits 13:0
   typedef struct packed {
      logic             ie;
      logic             frz;
      logic             byp;
      logic             run;
      logic             pol;
      logic             dir;
      logic [PSC_W-1:0] psc;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_pkg::*;
#(
   parameter int W = PSC_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         frozen,
   input  logic [W-1:0] reload,
   output logic         tick
);
   logic [W-1:0] pre;

   if (W < 1) begin : g_bad_w
      $error("pwm_prescaler: W must be at least 1");
   end

   assign tick = run && !frozen && (pre == {W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n)         pre <= '0;
      else if (!run)      pre <= reload;
      else if (!frozen) begin
         if (tick)        pre <= reload;
         else             pre <= pre + W'(1);
      end
   end

   AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run && frozen)) |-> $stable(pre)); // R9
endmodule

// File: rtl/pwm_buffers.sv
module pwm_buffers #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         byp,
   input  logic         wrap,
   input  logic         wr_per,
   input  logic         wr_pw,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] buf_per,
   output logic [W-1:0] buf_pw,
   output logic [W-1:0] work_per,
   output logic [W-1:0] work_pw
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_per <= '0;
         buf_pw  <= '0;
      end else begin
         if (wr_per) buf_per <= wdata;
         if (wr_pw)  buf_pw  <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         work_per <= '0;
         work_pw  <= '0;
      end else if (!run) begin
         work_per <= buf_per;
         work_pw  <= buf_pw;
      end else begin
         if (wr_per && byp) work_per <= wdata;
         else if (wrap)     work_per <= buf_per;
         if (wr_pw && byp)  work_pw  <= wdata;
         else if (wrap)     work_pw  <= buf_pw;
      end
   end

   AST_BYPASS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run && byp && wr_pw)) |-> (work_pw == $past(wdata))); // R8
   AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run && !wrap && !(byp && wr_pw))) |-> $stable(work_pw)); // R7
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         frozen,
   input  logic         tick,
   input  logic [W-1:0] work_per,
   input  logic [W-1:0] work_pw,
   output logic         wrap,
   output logic         out_q
);
   logic [W-1:0] cnt;
   logic         last;
   logic         active;

   assign last   = (work_per <= W'(1)) || (cnt >= work_per - W'(1));
   assign wrap   = tick && last;
   assign active = (work_pw != '0) &&
                   ((work_pw >= work_per) || (cnt >= work_per - work_pw));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt   <= '0;
         out_q <= 1'b0;
      end else if (!frozen) begin
         out_q <= active;
         if (wrap)      cnt <= '0;
         else if (tick) cnt <= cnt + W'(1);
      end
   end

   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run && frozen)) |-> ($stable(cnt) && $stable(out_q))); // R9
   AST_ZERO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run && !frozen && work_pw == '0)) |-> !out_q); // R6
   AST_FULL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run && !frozen && work_pw != '0 && work_pw >= work_per)) |-> out_q); // R6
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   input  logic          pin_in,
   output logic          pin_out,
   output logic          pin_oe,
   input  logic          freeze_in,
   output logic          irq
);
   if (CNT_W < 2 || CNT_W > DW) begin : g_bad_cnt
      $error("pwm_channel: CNT_W must lie in 2..16");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("pwm_channel: SYNC_STAGES must not exceed 4");
   end

   ctl_t             ctl;
   logic             flag;
   logic             out_q, out_d;
   logic             tick, wrap, frozen, pin_lvl;
   logic [CNT_W-1:0] buf_per, buf_pw, work_per, work_pw;
   logic [DW-1:0]    per_rd, pw_rd;
   logic             unused_wd;

   assign unused_wd = ^wr_data;

   // register writes
   always_ff @(posedge clk) begin
      if (!rst_n)                        ctl <= '0;
      else if (wr_en && addr == A_CTL)   ctl <= ctl_t'(wr_data[CTL_W-1:0]);
   end

   assign frozen = ctl.frz && freeze_in;

   // pin level synchroniser variant
   if (SYNC_STAGES == 0) begin : g_direct
      assign pin_lvl = pin_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk) begin
         if (!rst_n) sr <= '0;
         else begin
            sr[0] <= pin_in;
            for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
         end
      end
      assign pin_lvl = sr[SYNC_STAGES-1];
   end

   pwm_prescaler #(.W(PSC_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctl.run), .frozen(frozen),
      .reload(ctl.psc), .tick(tick)
   );

   pwm_buffers #(.W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .run(ctl.run), .byp(ctl.byp), .wrap(wrap),
      .wr_per(wr_en && addr == A_PER), .wr_pw(wr_en && addr == A_PW),
      .wdata(wr_data[CNT_W-1:0]),
      .buf_per(buf_per), .buf_pw(buf_pw),
      .work_per(work_per), .work_pw(work_pw)
   );

   pwm_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(ctl.run), .frozen(frozen), .tick(tick),
      .work_per(work_per), .work_pw(work_pw), .wrap(wrap), .out_q(out_q)
   );

   // period-end edge flag
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_d <= 1'b0;
         flag  <= 1'b0;
      end else begin
         out_d <= out_q;
         if (ctl.run && out_d && !out_q)                  flag <= 1'b1;
         else if (wr_en && addr == A_STS && wr_data[0])   flag <= 1'b0;
      end
   end

   assign irq = flag && ctl.ie;

   // pin role
   always_comb begin
      if (ctl.run) begin
         pin_oe  = 1'b1;
         pin_out = out_q ^ ctl.pol;
      end else begin
         pin_oe  = ctl.dir;
         pin_out = ctl.pol;
      end
   end

   // read path, zero padded when CNT_W is narrow
   if (CNT_W == DW) begin : g_full
      assign per_rd = buf_per;
      assign pw_rd  = buf_pw;
   end else begin : g_pad
      assign per_rd = {{(DW-CNT_W){1'b0}}, buf_per};
      assign pw_rd  = {{(DW-CNT_W){1'b0}}, buf_pw};
   end

   always_comb begin
      unique case (addr)
         A_PER:   rd_data = per_rd;
         A_PW:    rd_data = pw_rd;
         A_CTL:   rd_data = {{(DW-CTL_W-1){1'b0}}, pin_lvl, ctl};
         default: rd_data = {{(DW-1){1'b0}}, flag};
      endcase
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag) && !$past(wr_en && addr == A_STS && wr_data[0])) |-> flag); // R10
endmodule

// File: tb/tb_pwm_channel.sv
module tb_pwm_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        pin_in = 1'b0;
   logic        pin_out, pin_oe, irq;
   logic        freeze_in = 1'b0;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_tag = "R5";
   bit    sb_q[$];

   localparam int DIR = 1 << 8;
   localparam int POL = 1 << 9;
   localparam int RUN = 1 << 10;
   localparam int BYP = 1 << 11;
   localparam int FRZ = 1 << 12;
   localparam int IE  = 1 << 13;

   pwm_channel dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .freeze_in(freeze_in), .irq(irq)
   );

   always #5 clk = ~clk;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected pin levels as the design produces them
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         bit e;
         e = sb_q.pop_front();
         check({cur_tag, " pin_out"}, 32'(pin_out), 32'(e));
         check({cur_tag, " pin_oe"}, 32'(pin_oe), 32'd1);
      end
   end

   task automatic reg_wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 2'(a); wr_data = 16'(d);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string tag, int a, int exp, int mask);
      @(negedge clk);
      addr = 2'(a);
      #1;
      check(tag, 32'(rd_data) & 32'(mask), 32'(exp));
   endtask

   // expected active level after n edges from the enable edge
   function automatic bit mdl(int n, int per, int dv, int pw_a, int pw_b, int sw);
      int k, pw, c;
      if (n == 0) return 1'b0;
      k  = n - 1;
      pw = (k >= sw) ? pw_b : pw_a;
      c  = (k / dv) % per;
      return (pw != 0) && ((pw >= per) || (c >= per - pw));
   endfunction

   task automatic run_pwm(string tag, int per, int pw0, int pw1, int psc,
                          bit pol, int extra, int w, bit hold, int n);
      int dv, sw, base;
      dv   = 256 - psc;
      base = psc | (pol ? POL : 0) | extra;
      reg_wr(2, base);
      reg_wr(0, per);
      reg_wr(1, pw0);
      reg_wr(2, base | RUN);
      cur_tag = tag;
      if (w == 0)           sw = 1 << 30;
      else if (extra & BYP) sw = w;
      else                  sw = ((w / (dv * per)) + 1) * dv * per;
      for (int i = 0; i <= n; i++)
         sb_q.push_back(hold ? pol : (mdl(i, per, dv, pw0, pw1, sw) ^ pol));
      if (w > 0) begin
         repeat (w - 1) @(posedge clk);
         reg_wr(1, pw1);
      end
      wait (sb_q.size() == 0);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      rd_chk("R2 reset ctl", 2, 0, 16'hFFFF);
      check("R2 reset oe", 32'(pin_oe), 0);
      check("R10 reset irq", 32'(irq), 0);

      // R11 buffer readback
      reg_wr(0, 16'h1234);
      reg_wr(1, 16'h00A5);
      rd_chk("R11 period", 0, 16'h1234, 16'hFFFF);
      rd_chk("R11 pulse", 1, 16'h00A5, 16'hFFFF);

      // R1 pin level, read-only and reserved bits
      pin_in = 1'b1;
      repeat (4) @(posedge clk);
      rd_chk("R1 pin high", 2, 16'h4000, 16'h4000);
      reg_wr(2, 16'h8000);
      rd_chk("R1 write ignored hi", 2, 16'h4000, 16'hC000);
      pin_in = 1'b0;
      reg_wr(2, 16'hC000);
      repeat (4) @(posedge clk);
      rd_chk("R1 pin low", 2, 16'h0000, 16'hC000);

      // R2/R3 static roles
      reg_wr(2, DIR);
      @(negedge clk);
      check("R2 dir out oe", 32'(pin_oe), 1);
      check("R3 static low", 32'(pin_out), 0);
      reg_wr(2, DIR | POL);
      @(negedge clk);
      check("R3 static high", 32'(pin_out), 1);
      reg_wr(2, POL);
      @(negedge clk);
      check("R2 input oe", 32'(pin_oe), 0);

      // R5 / R4 waveforms
      run_pwm("R5 high pulse", 5, 2, 2, 8'hFF, 1'b0, 0, 0, 1'b0, 12);
      run_pwm("R4 R5 low pulse div2", 5, 2, 2, 8'hFE, 1'b1, DIR, 0, 1'b0, 24);
      run_pwm("R4 div3", 3, 1, 1, 8'hFD, 1'b0, 0, 0, 1'b0, 20);

      // R6 extremes
      run_pwm("R6 zero pulse", 4, 0, 0, 8'hFF, 1'b0, 0, 0, 1'b0, 10);
      run_pwm("R6 full pulse", 4, 4, 4, 8'hFF, 1'b0, 0, 0, 1'b0, 10);
      run_pwm("R6 over pulse", 4, 7, 7, 8'hFF, 1'b1, 0, 0, 1'b0, 10);

      // R7 buffered and R8 bypassed mid-run pulse change
      run_pwm("R7 buffered", 4, 1, 3, 8'hFF, 1'b0, 0, 2, 1'b0, 16);
      run_pwm("R8 bypass", 4, 1, 3, 8'hFF, 1'b0, BYP, 2, 1'b0, 16);

      // R9 freeze qualified and ignored
      freeze_in = 1'b1;
      run_pwm("R9 frozen", 4, 4, 4, 8'hFF, 1'b0, FRZ, 0, 1'b1, 12);
      run_pwm("R9 freeze ignored", 4, 2, 2, 8'hFF, 1'b0, 0, 0, 1'b0, 12);
      freeze_in = 1'b0;

      // R10 flag and irq gating
      run_pwm("R10 run ie", 4, 2, 2, 8'hFF, 1'b0, IE, 0, 1'b0, 10);
      rd_chk("R10 flag set", 3, 1, 16'hFFFF);
      check("R10 irq high", 32'(irq), 1);
      reg_wr(2, IE);
      reg_wr(3, 1);
      rd_chk("R10 flag cleared", 3, 0, 16'hFFFF);
      check("R10 irq low", 32'(irq), 0);
      run_pwm("R10 run no ie", 4, 2, 2, 8'hFF, 1'b0, 0, 0, 1'b0, 10);
      rd_chk("R10 flag set no ie", 3, 1, 16'hFFFF);
      check("R10 irq gated", 32'(irq), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule